// File: doc/BRIEF.md
# Mixed-Width Simple Dual-Port RAM

This block is a 4,608-bit memory with one write port and one read port, each on its own clock. A static mode input on each port sets its width. The write port and the read port can use different widths, so data written as 4-bit words can be read back one bit at a time, or written as 18-bit words and read as 9-bit bytes.

The store is organised as 512 lanes of nine bits. The 1, 2 and 4-bit modes see only the low eight bits of each lane, which gives 4,096 addressable data bits. The 9 and 18-bit modes also see the ninth bit. A separate preload port writes whole lanes, one per write-clock cycle. After preload the memory can serve as a ROM. Reads are synchronous and registered. The read register is the only state that reset touches.

Top module: `mwram_dp`

## Requirements
- R1: The store holds 512 lanes of 9 bits. On a rising wclk edge with `init_en` high, `init_data` is written to lane `init_addr`. This takes priority over the write port in that cycle.
- R2: The mode code on `wr_mode` and `rd_mode` selects the port width: 0 = 1 bit (4096 deep), 1 = 2 bits (2048), 2 = 4 bits (1024), 3 = 9 bits (512), 4 = 18 bits (256). Codes 5 to 7 behave as code 0.
- R3: In the 1, 2 and 4-bit modes, word k of width w covers data bits k·w to k·w+w−1, with the LSB at the lowest index. Data bit d lives in lane d/8, at lane bit d mod 8.
- R4: In 9-bit mode, word k is lane k, all nine bits, with bit 8 being the ninth bit.
- R5: In 18-bit mode, word k is lane 2k (data bits 8:0) together with lane 2k+1 (data bits 17:9).
- R6: Address bits above the depth of the selected mode are ignored.
- R7: A 1, 2 or 4-bit write changes only its own bits. Every other bit of the lane, including the ninth bit, keeps its value.
- R8: A read is synchronous. On a rising rclk edge with `re` high, `rd_data` takes the word at `raddr` in `rd_mode`. Output bits above the mode width are zero.
- R9: While `re` is low, `rd_data` holds its value.
- R10: When a read and a write hit the same location at the same clock edge, the read returns the old contents.
- R11: A synchronous active-high `rst`, sampled on rclk, clears `rd_data` to zero. The stored contents are left intact.
- R12: Any write width can be paired with any read width, and every read matches a flat bit-array model of the store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write and preload clock |
| rst | input | 1 | Synchronous active-high reset of the read register |
| we | input | 1 | Write enable |
| wr_mode | input | 3 | Write port width code |
| waddr | input | 12 | Write address |
| wdata | input | 18 | Write data, LSB aligned |
| rclk | input | 1 | Read clock |
| re | input | 1 | Read enable |
| rd_mode | input | 3 | Read port width code |
| raddr | input | 12 | Read address |
| rd_data | output | 18 | Registered read data, LSB aligned |
| init_en | input | 1 | Preload strobe |
| init_addr | input | 9 | Preload lane index |
| init_data | input | 9 | Preload lane contents |

## Verification
The bench targets cross-width aliasing, where one location is written at one width and read at another. A design that counted the ninth bit into the narrow-mode bit offset would return data from the wrong lane position. A nibble write into a lane that already holds a 9-bit value must leave the other nibble and the ninth bit unchanged; a design that wrote the whole lane would clear them. The bench also checks the upper 18-bit half, ignored address bits, the reserved mode codes, old-data return on a colliding read, holding while `re` is low, and that reset leaves the memory contents alone. Each of these has a directed check. A random phase then runs all width pairs against a flat bit model.

// File: rtl/mwram_pkg.sv
package mwram_pkg;

    localparam int LANE_W    = 9;
    localparam int LANE_DATA = LANE_W - 1;
    localparam int NUM_LANES = 512;
    localparam int LANE_AW   = $clog2(NUM_LANES);
    localparam int ADDR_W    = 12;
    localparam int DATA_W    = 2 * LANE_W;
    localparam int BIT_AW    = $clog2(LANE_DATA);

    typedef enum logic [2:0] {
        MODE_X1  = 3'd0,
        MODE_X2  = 3'd1,
        MODE_X4  = 3'd2,
        MODE_X9  = 3'd3,
        MODE_X18 = 3'd4
    } port_mode_e;

    typedef struct packed {
        logic [LANE_AW-1:0] lane0;
        logic [LANE_AW-1:0] lane1;
        logic               pair;
        logic [BIT_AW-1:0]  bitpos;
        logic [LANE_W-1:0]  fmask;
    } lane_sel_t;

    function automatic lane_sel_t map_addr(input logic [2:0] mode,
                                           input logic [ADDR_W-1:0] addr);
        lane_sel_t         s;
        logic [ADDR_W-1:0] dbit;
        logic [LANE_W-1:0] base;
        s    = '0;
        dbit = '0;
        base = '0;
        case (mode)
            MODE_X9: begin
                s.lane0 = addr[LANE_AW-1:0];
                s.lane1 = addr[LANE_AW-1:0];
                s.fmask = '1;
            end
            MODE_X18: begin
                s.lane0 = {addr[LANE_AW-2:0], 1'b0};
                s.lane1 = {addr[LANE_AW-2:0], 1'b1};
                s.pair  = 1'b1;
                s.fmask = '1;
            end
            default: begin
                if (mode == MODE_X2) begin
                    dbit = {addr[ADDR_W-2:0], 1'b0};
                    base = 9'h003;
                end else if (mode == MODE_X4) begin
                    dbit = {addr[ADDR_W-3:0], 2'b00};
                    base = 9'h00F;
                end else begin
                    dbit = addr;
                    base = 9'h001;
                end
                s.lane0  = dbit[ADDR_W-1:BIT_AW];
                s.lane1  = dbit[ADDR_W-1:BIT_AW];
                s.bitpos = dbit[BIT_AW-1:0];
                s.fmask  = base << dbit[BIT_AW-1:0];
            end
        endcase
        return s;
    endfunction

endpackage

// File: rtl/mwram_wr_map.sv
module mwram_wr_map
    import mwram_pkg::*;
(
    input  logic [2:0]         mode,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  data,
    output logic [LANE_AW-1:0] lane0,
    output logic [LANE_AW-1:0] lane1,
    output logic               pair,
    output logic [LANE_W-1:0]  mask0,
    output logic [LANE_W-1:0]  dat0,
    output logic [LANE_W-1:0]  mask1,
    output logic [LANE_W-1:0]  dat1
);
    lane_sel_t sel;

    always_comb begin
        sel   = map_addr(mode, addr);
        lane0 = sel.lane0;
        lane1 = sel.lane1;
        pair  = sel.pair;
        mask0 = sel.fmask;
        mask1 = sel.pair ? sel.fmask : '0;
        dat0  = (data[LANE_W-1:0] << sel.bitpos) & sel.fmask;
        dat1  = data[DATA_W-1:LANE_W];
    end
endmodule

// File: rtl/mwram_store.sv
module mwram_store
    import mwram_pkg::*;
(
    input  logic               wclk,
    input  logic               init_en,
    input  logic [LANE_AW-1:0] init_addr,
    input  logic [LANE_W-1:0]  init_data,
    input  logic               we,
    input  logic [LANE_AW-1:0] wl0,
    input  logic [LANE_AW-1:0] wl1,
    input  logic               wpair,
    input  logic [LANE_W-1:0]  wm0,
    input  logic [LANE_W-1:0]  wd0,
    input  logic [LANE_W-1:0]  wm1,
    input  logic [LANE_W-1:0]  wd1,
    input  logic [LANE_AW-1:0] rl0,
    input  logic [LANE_AW-1:0] rl1,
    output logic [LANE_W-1:0]  rq0,
    output logic [LANE_W-1:0]  rq1
);
    logic [LANE_W-1:0] mem [NUM_LANES];

    always_ff @(posedge wclk) begin
        if (init_en) begin
            mem[init_addr] <= init_data;
        end else if (we) begin
            mem[wl0] <= (mem[wl0] & ~wm0) | (wd0 & wm0);
            if (wpair) begin
                mem[wl1] <= (mem[wl1] & ~wm1) | (wd1 & wm1);
            end
        end
    end

    assign rq0 = mem[rl0];
    assign rq1 = mem[rl1];
endmodule

// File: rtl/mwram_rd_path.sv
module mwram_rd_path
    import mwram_pkg::*;
(
    input  logic               rclk,
    input  logic               rst,
    input  logic               re,
    input  logic [2:0]         mode,
    input  logic [ADDR_W-1:0]  addr,
    output logic [LANE_AW-1:0] rl0,
    output logic [LANE_AW-1:0] rl1,
    input  logic [LANE_W-1:0]  rq0,
    input  logic [LANE_W-1:0]  rq1,
    output logic [DATA_W-1:0]  rd_data
);
    lane_sel_t         sel;
    logic [DATA_W-1:0] nxt;

    always_comb begin
        sel = map_addr(mode, addr);
        rl0 = sel.lane0;
        rl1 = sel.lane1;
        case (mode)
            MODE_X9:  nxt = {{LANE_W{1'b0}}, rq0};
            MODE_X18: nxt = {rq1, rq0};
            default:  nxt = {{LANE_W{1'b0}}, ((rq0 & sel.fmask) >> sel.bitpos)};
        endcase
    end

    always_ff @(posedge rclk) begin
        if (rst) begin
            rd_data <= '0;
        end else if (re) begin
            rd_data <= nxt;
        end
    end

    // R11
    rst_clear_chk: assert property (@(posedge rclk) rst |=> rd_data == '0);

    // R9
    hold_idle_chk: assert property (@(posedge rclk) disable iff (rst)
        !re |=> $stable(rd_data));

    // R8
    narrow_upper_chk: assert property (@(posedge rclk) disable iff (rst)
        (re && mode inside {3'd0, 3'd1, 3'd2}) |=> rd_data[DATA_W-1:4] == '0);
endmodule

// File: rtl/mwram_dp.sv
module mwram_dp
    import mwram_pkg::*;
(
    input  logic              wclk,
    input  logic              rst,
    input  logic              we,
    input  logic [2:0]        wr_mode,
    input  logic [11:0]       waddr,
    input  logic [17:0]       wdata,
    input  logic              rclk,
    input  logic              re,
    input  logic [2:0]        rd_mode,
    input  logic [11:0]       raddr,
    output logic [17:0]       rd_data,
    input  logic              init_en,
    input  logic [8:0]        init_addr,
    input  logic [8:0]        init_data
);
    logic [LANE_AW-1:0] wl0, wl1, rl0, rl1;
    logic               wpair;
    logic [LANE_W-1:0]  wm0, wd0, wm1, wd1, rq0, rq1;

    mwram_wr_map u_wr_map (
        .mode  (wr_mode),
        .addr  (waddr),
        .data  (wdata),
        .lane0 (wl0),
        .lane1 (wl1),
        .pair  (wpair),
        .mask0 (wm0),
        .dat0  (wd0),
        .mask1 (wm1),
        .dat1  (wd1)
    );

    mwram_store u_store (
        .wclk      (wclk),
        .init_en   (init_en),
        .init_addr (init_addr),
        .init_data (init_data),
        .we        (we),
        .wl0       (wl0),
        .wl1       (wl1),
        .wpair     (wpair),
        .wm0       (wm0),
        .wd0       (wd0),
        .wm1       (wm1),
        .wd1       (wd1),
        .rl0       (rl0),
        .rl1       (rl1),
        .rq0       (rq0),
        .rq1       (rq1)
    );

    mwram_rd_path u_rd_path (
        .rclk    (rclk),
        .rst     (rst),
        .re      (re),
        .mode    (rd_mode),
        .addr    (raddr),
        .rl0     (rl0),
        .rl1     (rl1),
        .rq0     (rq0),
        .rq1     (rq1),
        .rd_data (rd_data)
    );

    // R7
    narrow_ninth_chk: assert property (@(posedge wclk) disable iff (rst)
        (we && !init_en && wr_mode inside {3'd0, 3'd1, 3'd2}) |-> !wm0[LANE_W-1]);

    // R5
    pair_lanes_chk: assert property (@(posedge wclk) disable iff (rst)
        wpair |-> ((wl1 == wl0 + 1'b1) && !wl0[0]));
endmodule

// File: tb/tb_mwram_dp.sv
module tb_mwram_dp;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        we = 1'b0, re = 1'b0, init_en = 1'b0;
    logic [2:0]  wr_mode = 3'd0, rd_mode = 3'd0;
    logic [11:0] waddr = '0, raddr = '0;
    logic [17:0] wdata = '0;
    logic [8:0]  init_addr = '0, init_data = '0;
    logic [17:0] rd_data;

    int checks = 0;
    int fails  = 0;
    bit refm [4608];

    always #(CLK_PERIOD/2) clk = ~clk;

    mwram_dp dut (
        .wclk(clk), .rst(rst), .we(we), .wr_mode(wr_mode), .waddr(waddr),
        .wdata(wdata), .rclk(clk), .re(re), .rd_mode(rd_mode), .raddr(raddr),
        .rd_data(rd_data), .init_en(init_en), .init_addr(init_addr),
        .init_data(init_data)
    );

    typedef struct packed {
        logic [2:0]  wm;
        logic [11:0] wa;
        logic [17:0] wd;
        logic [2:0]  rm;
        logic [11:0] ra;
        logic [17:0] ex;
    } vec_t;

    localparam vec_t VECS [9] = '{
        '{3'd2, 12'd5,     18'h0000A, 3'd0, 12'd21,  18'h00001}, // R3 nibble in, bit out
        '{3'd0, 12'd100,   18'h00001, 3'd2, 12'd25,  18'h00001}, // R3 bit in, nibble out
        '{3'd1, 12'd300,   18'h00003, 3'd3, 12'd75,  18'h00003}, // R3 R4 pair in, lane out
        '{3'd3, 12'd200,   18'h001A5, 3'd2, 12'd400, 18'h00005}, // R4 lane in, nibble out
        '{3'd4, 12'd10,    18'h3C0F1, 3'd2, 12'd43,  18'h0000E}, // R5 upper half lane
        '{3'd4, 12'd200,   18'h2AB55, 3'd4, 12'd200, 18'h2AB55}, // R5 full width round trip
        '{3'd2, 12'd1023,  18'h00009, 3'd3, 12'd511, 18'h00090}, // R3 last nibble
        '{3'd3, 12'hE07,   18'h00155, 3'd3, 12'd7,   18'h00155}, // R6 upper address ignored
        '{3'd2, 12'd401,   18'h00000, 3'd3, 12'd200, 18'h00105}  // R7 ninth bit kept
    };

    function automatic int phys(input int d);
        return (d / 8) * 9 + (d % 8);
    endfunction

    function automatic int mwidth(input logic [2:0] m);
        case (m)
            3'd1: return 2;
            3'd2: return 4;
            3'd3: return 9;
            3'd4: return 18;
            default: return 1;
        endcase
    endfunction

    function automatic int pos(input logic [2:0] m, input logic [11:0] a, input int i);
        int w;
        w = mwidth(m);
        if (w == 9)  return int'(a[8:0]) * 9 + i;
        if (w == 18) return int'(a[7:0]) * 18 + i;
        return phys((int'(a) % (4096 / w)) * w + i);
    endfunction

    task automatic ref_write(input logic [2:0] m, input logic [11:0] a, input logic [17:0] d);
        for (int i = 0; i < mwidth(m); i++) refm[pos(m, a, i)] = d[i];
    endtask

    function automatic logic [17:0] ref_read(input logic [2:0] m, input logic [11:0] a);
        logic [17:0] r;
        r = '0;
        for (int i = 0; i < mwidth(m); i++) r[i] = refm[pos(m, a, i)];
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input logic [17:0] act,
                         input logic [17:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [2:0] m, input logic [11:0] a, input logic [17:0] d);
        @(negedge clk);
        we = 1'b1; wr_mode = m; waddr = a; wdata = d;
        @(negedge clk);
        we = 1'b0;
        ref_write(m, a, d);
    endtask

    task automatic do_read(input logic [2:0] m, input logic [11:0] a, output logic [17:0] q);
        @(negedge clk);
        re = 1'b1; rd_mode = m; raddr = a;
        @(negedge clk);
        re = 1'b0;
        q = rd_data;
    endtask

    task automatic preload(input bit pattern);
        for (int i = 0; i < 512; i++) begin
            @(negedge clk);
            init_en = 1'b1; init_addr = 9'(i); init_data = pattern ? 9'(i) : 9'd0;
            for (int b = 0; b < 9; b++) refm[i * 9 + b] = pattern ? init_data[b] : 1'b0;
        end
        @(negedge clk);
        init_en = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=%h expected=%h", 18'h0, 18'h1);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [17:0] q, e;
        logic [11:0] ra;
        logic [2:0]  wm, rm;
        logic [11:0] wa;
        int          d;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(rd_data == 18'h0, "R11 reset value", rd_data, 18'h0);

        // R1 preload, then read as ROM
        preload(1'b1);
        do_read(3'd4, 12'd3, q);    check(q == 18'h00E06, "R1 R5 rom 18-bit", q, 18'h00E06);
        do_read(3'd0, 12'd40, q);   check(q == 18'h00001, "R1 R3 rom 1-bit", q, 18'h00001);
        do_read(3'd3, 12'd300, q);  check(q == 18'h0012C, "R1 R4 rom 9-bit", q, 18'h0012C);
        do_read(3'd1, 12'd2047, q); check(q == 18'h00003, "R1 R3 rom 2-bit", q, 18'h00003);
        do_read(3'd7, 12'd40, q);   check(q == 18'h00001, "R2 reserved code", q, 18'h00001);
        do_read(3'd0, 12'd41, q);   check(q == 18'h00000, "R2 R8 1-bit zero", q, 18'h00000);

        // R1 preload priority over a simultaneous write
        @(negedge clk);
        init_en = 1'b1; init_addr = 9'd9; init_data = 9'h0C3;
        we = 1'b1; wr_mode = 3'd3; waddr = 12'd9; wdata = 18'h0003C;
        @(negedge clk);
        init_en = 1'b0; we = 1'b0;
        for (int b = 0; b < 9; b++) refm[81 + b] = init_data[b];
        do_read(3'd3, 12'd9, q); check(q == 18'h000C3, "R1 preload priority", q, 18'h000C3);

        preload(1'b0);

        // R12 vector table
        for (int v = 0; v < 9; v++) begin
            do_write(VECS[v].wm, VECS[v].wa, VECS[v].wd);
            do_read(VECS[v].rm, VECS[v].ra, q);
            check(q == VECS[v].ex, $sformatf("R12 table vector %0d", v), q, VECS[v].ex);
        end

        // R10 colliding read returns old data
        @(negedge clk);
        we = 1'b1; wr_mode = 3'd3; waddr = 12'd30; wdata = 18'h000AA;
        re = 1'b1; rd_mode = 3'd3; raddr = 12'd30;
        @(negedge clk);
        we = 1'b0; re = 1'b0;
        ref_write(3'd3, 12'd30, 18'h000AA);
        check(rd_data == 18'h0, "R10 old data", rd_data, 18'h0);
        do_read(3'd3, 12'd30, q); check(q == 18'h000AA, "R10 new data after", q, 18'h000AA);

        // R9 hold while re low
        do_read(3'd3, 12'd200, q);
        @(negedge clk);
        rd_mode = 3'd4; raddr = 12'd7;
        repeat (3) @(negedge clk);
        check(rd_data == 18'h00105, "R9 hold", rd_data, 18'h00105);

        // R6 narrow upper address bits ignored
        do_read(3'd2, 12'hC19, q); check(q == 18'h00001, "R6 narrow alias", q, 18'h00001);

        // R11 reset clears output, keeps contents
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check(rd_data == 18'h0, "R11 reset clears", rd_data, 18'h0);
        do_read(3'd3, 12'd200, q); check(q == 18'h00105, "R11 contents kept", q, 18'h00105);

        // R12 random cross-width traffic
        for (int n = 0; n < 400; n++) begin
            wm = 3'($urandom_range(4, 0));
            rm = 3'($urandom_range(4, 0));
            wa = 12'($urandom);
            do_write(wm, wa, 18'($urandom));
            if (mwidth(wm) == 9)       d = int'(wa[8:0]) * 8;
            else if (mwidth(wm) == 18) d = int'(wa[7:0]) * 16;
            else                       d = (int'(wa) % (4096 / mwidth(wm))) * mwidth(wm);
            if (mwidth(rm) == 9)       ra = 12'(d / 8);
            else if (mwidth(rm) == 18) ra = 12'(d / 16);
            else                       ra = 12'(d / mwidth(rm));
            e = ref_read(rm, ra);
            do_read(rm, ra, q);
            check(q == e, "R12 random", q, e);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule